// File: doc/BRIEF.md
# Bit-Serial Adder with Carry State

The block adds two binary operands that arrive one bit pair per clock, lowest bit first. Its only memory between bit positions is the carry, so operands of any length can be summed with a single full-adder cell and a flip-flop. The sum leaves on a single serial output.

A build-time parameter picks one of two output styles. In the combinational-output style, the sum bit is formed from the current operand bits and the stored carry, so it appears in the same cycle as its inputs. In the registered-output style, the machine keeps a two-bit state that holds the pair (carry, sum), which gives four states, and the output is read straight from that state, so each sum bit appears one clock after its inputs. A synchronous clear zeroes the state before a new word starts. An enable input lets the feeding logic leave gaps between bits without losing the carry.

Top module: `bsa_serial_adder`

## Requirements
- R1: Operand bits presented on enabled cycles, lowest first, produce the serial bits of (A + B) modulo 2^n for an n-bit word, with no extra delay in the combinational style and with a delay of one clock in the registered style.
- R2: With MOORE = 0, sum_bit equals a_bit xor b_bit xor the stored carry in the same cycle, with no clock edge in between.
- R3: On an enabled, uncleared clock edge the stored carry becomes 1 exactly when at least two of a_bit, b_bit and the old carry are 1.
- R4: With MOORE = 1, sum_bit after an enabled, uncleared edge equals a_bit xor b_bit xor carry as sampled at that edge, and it only changes at clock edges.
- R5: A clock edge with clr = 1 sets the carry to 0, whatever en is; with MOORE = 1 it also sets sum_bit to 0.
- R6: A clock edge with en = 0 and clr = 0 leaves the carry unchanged, and with MOORE = 1 it leaves sum_bit unchanged; a word fed with idle gaps gives the same sum as one fed without them.
- R7: A clock edge with rst = 1 sets the carry to 0 and, with MOORE = 1, sum_bit to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear before a new word, active high, overrides en |
| en | input | 1 | Accepts the current bit pair when high; holds the state when low |
| a_bit | input | 1 | Serial bit of operand A, lowest first |
| b_bit | input | 1 | Serial bit of operand B, lowest first |
| sum_bit | output | 1 | Serial sum bit |

## Verification
The clear and the enable can both be high in the same cycle. That is the point where a word ends and the next one begins, and a wrong priority leaves a stale carry in the new word. The bench drives clr and en together while a_bit and b_bit are both 1, so an adder that let en win would store a carry of 1. It then expects a zero carry on the next bit and a zero sum in the registered style. Both output styles run side by side against one reference model, and each word result is also compared with the integer sum.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // Registered-output state: stored carry and the sum bit on the output
  typedef struct packed {
    logic carry;
    logic sum;
  } bsa_state_t;

  localparam int unsigned STATE_W = $bits(bsa_state_t);
endpackage

// File: rtl/bsa_full_add.sv
module bsa_full_add (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  always_comb begin
    s_o = a_i ^ b_i ^ c_i;
    c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  end
endmodule

// File: rtl/bsa_state_reg.sv
module bsa_state_reg #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= d;
  end
endmodule

// File: rtl/bsa_serial_adder.sv
module bsa_serial_adder #(
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit
);
  import bsa_pkg::*;

  logic carry_q;
  logic fa_sum;
  logic fa_carry;

  bsa_full_add u_fa (
    .a_i(a_bit),
    .b_i(b_bit),
    .c_i(carry_q),
    .s_o(fa_sum),
    .c_o(fa_carry)
  );

  generate
    if (MOORE) begin : g_registered
      bsa_state_t st_d;
      bsa_state_t st_q;

      always_comb begin
        st_d.carry = fa_carry;
        st_d.sum   = fa_sum;
      end

      bsa_state_reg #(.WIDTH(STATE_W)) u_state (
        .clk(clk),
        .rst(rst),
        .clr(clr),
        .en (en),
        .d  (st_d),
        .q  (st_q)
      );

      assign carry_q = st_q.carry;
      assign sum_bit = st_q.sum;
    end else begin : g_comb_out
      logic c_q;

      bsa_state_reg #(.WIDTH(1)) u_carry (
        .clk(clk),
        .rst(rst),
        .clr(clr),
        .en (en),
        .d  (fa_carry),
        .q  (c_q)
      );

      assign carry_q = c_q;
      assign sum_bit = fa_sum;
    end
  endgenerate
endmodule

// File: rtl/bsa_serial_adder_chk.sv
module bsa_serial_adder_chk #(
  parameter bit MOORE = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic en,
  input logic a_bit,
  input logic b_bit,
  input logic sum_bit,
  input logic carry_q
);
  assert_reset_carry_R7: assert property (@(posedge clk) rst |=> !carry_q);

  assert_clear_carry_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> !carry_q);

  assert_carry_majority_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> carry_q == (($past(a_bit) & $past(b_bit)) |
                                 ($past(a_bit) & $past(carry_q)) |
                                 ($past(b_bit) & $past(carry_q))));

  assert_idle_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(carry_q));

  generate
    if (MOORE) begin : g_reg_checks
      assert_reset_sum_R7: assert property (@(posedge clk) rst |=> !sum_bit);

      assert_clear_sum_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !sum_bit);

      assert_delayed_sum_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> sum_bit == ($past(a_bit) ^ $past(b_bit) ^ $past(carry_q)));

      assert_idle_sum_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(sum_bit));
    end
  endgenerate
endmodule

bind bsa_serial_adder bsa_serial_adder_chk #(.MOORE(MOORE)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .clr    (clr),
  .en     (en),
  .a_bit  (a_bit),
  .b_bit  (b_bit),
  .sum_bit(sum_bit),
  .carry_q(carry_q)
);

// File: tb/bsa_serial_adder_tb.sv
`timescale 1ns/1ps
module bsa_serial_adder_tb;
  localparam int WORD_W = 8;

  typedef struct {
    logic  comb_exp;
    logic  reg_exp;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic en  = 1'b0;
  logic a_bit = 1'b0;
  logic b_bit = 1'b0;
  logic sum_comb;
  logic sum_reg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exp_t sb_q[$];
  logic mc = 1'b0;
  logic mz = 1'b0;
  logic got_comb;
  logic got_reg;

  always #2 clk = ~clk;

  bsa_serial_adder #(.MOORE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .en(en),
    .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_comb)
  );

  bsa_serial_adder #(.MOORE(1'b1)) u_dut_moore (
    .clk(clk), .rst(rst), .clr(clr), .en(en),
    .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_reg)
  );

  // Monitor: pops one expectation per cycle and compares both outputs
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      checks += 2;
      if (sum_comb !== it.comb_exp) begin
        errors++;
        $display("FAIL %s comb-out sum: got %b expected %b", it.tag, sum_comb, it.comb_exp);
      end
      if (sum_reg !== it.reg_exp) begin
        errors++;
        $display("FAIL %s registered sum: got %b expected %b", it.tag, sum_reg, it.reg_exp);
      end
    end
  end

  // Driver: one cycle of stimulus, expectation pushed before the sampling edge
  task automatic step(input logic a, input logic b, input logic e,
                      input logic c, input logic r, input string tag);
    exp_t it;
    a_bit = a; b_bit = b; en = e; clr = c; rst = r;
    it.comb_exp = a ^ b ^ mc;
    it.reg_exp  = mz;
    it.tag      = tag;
    sb_q.push_back(it);
    @(negedge clk);
    got_comb = sum_comb;
    got_reg  = sum_reg;
    if (r || c) begin
      mc = 1'b0; mz = 1'b0;
    end else if (e) begin
      mz = a ^ b ^ mc;
      mc = (a & b) | (a & mc) | (b & mc);
    end
    @(posedge clk); #1;
  endtask

  task automatic check_word(input string tag, input logic [WORD_W-1:0] got,
                            input logic [WORD_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s word: got %h expected %h", tag, got, exp);
    end
  endtask

  // Adds one word; gap_every > 0 inserts an idle cycle after that many bits
  task automatic add_word(input logic [WORD_W-1:0] x, input logic [WORD_W-1:0] y,
                          input int gap_every, input string tag);
    logic [WORD_W-1:0] gc;
    logic [WORD_W-1:0] gr;
    logic [WORD_W-1:0] expw;
    expw = x + y;
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, {tag, " R5 clear"});
    for (int i = 0; i < WORD_W; i++) begin
      step(x[i], y[i], 1'b1, 1'b0, 1'b0, {tag, " R2 R3 R4 bit"});
      gc[i] = got_comb;
      if (i > 0) gr[i-1] = got_reg;
      if (gap_every > 0 && (i % gap_every) == gap_every - 1)
        step(~x[i], y[i], 1'b0, 1'b0, 1'b0, {tag, " R6 idle"});
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, {tag, " R6 idle tail"});
    gr[WORD_W-1] = got_reg;
    check_word({tag, " R1 comb-out"}, gc, expw);
    check_word({tag, " R1 registered"}, gr, expw);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    // R7: reset state with ones on the operands
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7 reset");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7 reset");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 after reset");

    add_word(8'h00, 8'h00, 0, "zeros");
    add_word(8'hFF, 8'h01, 0, "ripple carry");
    add_word(8'hFF, 8'hFF, 0, "all ones");
    add_word(8'hA5, 8'h5A, 0, "alternating");
    add_word(8'h3C, 8'h77, 2, "gapped R6");
    add_word(8'h96, 8'hE9, 1, "every-bit gaps R6");

    // R5: clear together with enable while a carry would be generated
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 carry set");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 clear beats enable");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 carry zero after clear");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 sum zero after clear");
    // R6: carry held across a long idle stretch
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 carry set");
    for (int k = 0; k < 4; k++)
      step(k[0], ~k[0], 1'b0, 1'b0, 1'b0, "R6 hold");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 carry kept");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 delayed sum");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 delayed sum");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule